// File: doc/BRIEF.md
# Programmable-Modulus Phase Accumulator

This block is the phase engine of a direct digital synthesizer whose frequency ratio need not have a power-of-two denominator. A 32-bit main accumulator advances by a step every clock. In the plain tone mode the step is a 32-bit tuning word, so the output frequency is the tuning word over 2^32 times the clock.

In the fractional mode a second, auxiliary accumulator runs alongside. It adds a fractional increment each clock and wraps at a programmed modulus instead of at full scale. Every wrap adds one extra LSB to the main accumulator in that same cycle. The main accumulator also adds an integer step. The mean step per clock is therefore integer step + increment/modulus. Any ratio M/N with N up to 2^32 can be set this way.

All five values are loaded through a simple write port. The block's only output is the accumulated phase. Conversion from phase to amplitude happens downstream.

Top module: `pm_phase_accum`

## Requirements
- R1: While reset is asserted, and until the first write after it, the phase output is 0. All programmed values are 0 and the fractional mode is off.
- R2: With the mode bit clear, the phase grows by the tuning word (modulo 2^32) on every clock.
- R3: With the mode bit set, the phase grows on every clock by the integer step, plus 1 when the auxiliary accumulator wraps in that cycle. The tuning word has no effect in this mode.
- R4: In the fractional mode the auxiliary accumulator adds the increment on each clock. When the sum reaches or exceeds the modulus, the modulus is subtracted and one extra LSB is carried. With the increment below the modulus, every run of modulus clocks that starts from a cleared state yields exactly increment carries.
- R5: With the mode bit clear, the auxiliary accumulator is held at zero and produces no carry. Re-enabling the mode therefore restarts the fraction from zero.
- R6: A write to the modulus, the integer step, the increment or the control register clears the auxiliary accumulator. A write to the tuning word does not clear it.
- R7: The 3-bit write address decodes as follows: 0 is the tuning word, 1 the modulus, 2 the integer step, 3 the increment, and 4 the control register, whose bit 0 is the mode bit. A write to addresses 5 to 7 changes nothing.
- R8: A modulus of 0 in the fractional mode produces no carries. The phase then grows by the integer step alone.
- R9: A write takes effect on the increment made at the next clock edge. The increment made at the edge that captures the write still uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the configuration registers |
| wr_addr | input | 3 | Register select (see R7) |
| wr_data | input | 32 | Write data |
| phase_o | output | 32 | Accumulated phase |

## Verification
Every cycle, the assertions check four things. In the fractional mode the phase step is either the integer step or one more than it. Outside that mode the step is exactly the tuning word. The auxiliary accumulator stays below the modulus and is zero after a clearing write or while the mode is off. A zero modulus never carries. Some behaviour shows only over time, and only the bench's scenarios can show it. This covers the long-run carry count over a whole modulus period, the restart of the fraction after a clearing write or a mode toggle, and the one-edge delay before a write takes effect. The bench compares the output against its own model on every cycle under random write traffic.

// File: rtl/pma_pkg.sv
package pma_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    SEL_TUNE  = 3'd0,
    SEL_MOD   = 3'd1,
    SEL_ISTEP = 3'd2,
    SEL_FRAC  = 3'd3,
    SEL_CTRL  = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/pma_cfg_regs.sv
module pma_cfg_regs
  import pma_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      tune_o,
  output logic [W-1:0]      mod_o,
  output logic [W-1:0]      istep_o,
  output logic [W-1:0]      frac_o,
  output logic              mode_o,
  output logic              param_wr_o
);
  logic [W-1:0] tune_q, tune_d, mod_q, mod_d, istep_q, istep_d, frac_q, frac_d;
  logic         mode_q, mode_d;
  logic         clr;

  always_comb begin
    tune_d  = tune_q;
    mod_d   = mod_q;
    istep_d = istep_q;
    frac_d  = frac_q;
    mode_d  = mode_q;
    clr     = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        SEL_TUNE:  tune_d = wr_data;
        SEL_MOD:   begin mod_d   = wr_data; clr = 1'b1; end
        SEL_ISTEP: begin istep_d = wr_data; clr = 1'b1; end
        SEL_FRAC:  begin frac_d  = wr_data; clr = 1'b1; end
        SEL_CTRL:  begin mode_d  = wr_data[0]; clr = 1'b1; end
        default:   clr = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_q  <= '0;
      mod_q   <= '0;
      istep_q <= '0;
      frac_q  <= '0;
      mode_q  <= 1'b0;
    end else if (wr_en) begin
      tune_q  <= tune_d;
      mod_q   <= mod_d;
      istep_q <= istep_d;
      frac_q  <= frac_d;
      mode_q  <= mode_d;
    end
  end

  assign tune_o     = tune_q;
  assign mod_o      = mod_q;
  assign istep_o    = istep_q;
  assign frac_o     = frac_q;
  assign mode_o     = mode_q;
  assign param_wr_o = clr;
endmodule

// File: rtl/pma_aux_acc.sv
module pma_aux_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_i,
  input  logic         clr_i,
  input  logic [W-1:0] frac_i,
  input  logic [W-1:0] mod_i,
  output logic         carry_o,
  output logic [W-1:0] aux_o
);
  logic [W-1:0] aux_q, aux_d;
  logic [W:0]   sum, wrapped;
  logic         wrap;

  always_comb begin
    sum     = {1'b0, aux_q} + {1'b0, frac_i};
    wrapped = sum - {1'b0, mod_i};
    wrap    = mode_i && (mod_i != '0) && (sum >= {1'b0, mod_i});
    if (clr_i || !mode_i) begin
      aux_d = '0;
    end else if (wrap) begin
      aux_d = wrapped[W-1:0];
    end else begin
      aux_d = sum[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aux_q <= '0;
    else        aux_q <= aux_d;
  end

  assign carry_o = wrap;
  assign aux_o   = aux_q;
endmodule

// File: rtl/pma_phase_acc.sv
module pma_phase_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_i,
  input  logic [W-1:0] tune_i,
  input  logic [W-1:0] istep_i,
  input  logic         carry_i,
  output logic [W-1:0] phase_o
);
  logic [W-1:0] phase_q, phase_d, step;

  always_comb begin
    step    = mode_i ? istep_i : tune_i;
    phase_d = phase_q + step + {{(W-1){1'b0}}, carry_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/pm_phase_accum.sv
module pm_phase_accum
  import pma_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [PHASE_W-1:0] wr_data,
  output logic [PHASE_W-1:0] phase_o
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [PHASE_W-1:0]     tune_q, mod_q, istep_q, frac_q, aux_q, phase_q;
  logic                   mode_en, param_wr, carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  pma_cfg_regs #(.W(PHASE_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tune_o(tune_q), .mod_o(mod_q), .istep_o(istep_q),
    .frac_o(frac_q), .mode_o(mode_en), .param_wr_o(param_wr)
  );

  pma_aux_acc #(.W(PHASE_W)) u_aux (
    .clk(clk), .rst_n(rst_sync_n), .mode_i(mode_en), .clr_i(param_wr),
    .frac_i(frac_q), .mod_i(mod_q), .carry_o(carry), .aux_o(aux_q)
  );

  pma_phase_acc #(.W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_sync_n), .mode_i(mode_en), .tune_i(tune_q),
    .istep_i(istep_q), .carry_i(carry), .phase_o(phase_q)
  );

  assign phase_o = phase_q;
endmodule

// File: rtl/pma_checker.sv
module pma_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         mode_en,
  input logic         param_wr,
  input logic         carry,
  input logic [W-1:0] tune_q,
  input logic [W-1:0] mod_q,
  input logic [W-1:0] istep_q,
  input logic [W-1:0] frac_q,
  input logic [W-1:0] aux_q,
  input logic [W-1:0] phase_q
);
  // R2: plain tone step is exactly the tuning word
  assert_tone_step_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode_en |=> (phase_q - $past(phase_q)) == $past(tune_q));

  // R3: fractional step is integer step or one more
  assert_frac_step_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_en |=> ((phase_q - $past(phase_q)) == $past(istep_q)) ||
                ((phase_q - $past(phase_q)) == ($past(istep_q) + 1'b1)));

  // R4: auxiliary value stays below the modulus for a proper fraction
  assert_aux_bounded_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_en && (mod_q != '0) && (frac_q < mod_q)) |-> (aux_q < mod_q));

  // R5: auxiliary accumulator held at zero while the mode is off
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode_en |=> (aux_q == '0));

  // R6: a clearing write zeroes the auxiliary accumulator
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    param_wr |=> (aux_q == '0));

  // R8: zero modulus never carries
  assert_zero_mod_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mod_q == '0) |-> !carry);
endmodule

bind pm_phase_accum pma_checker #(.W(PHASE_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .mode_en(mode_en), .param_wr(param_wr),
  .carry(carry), .tune_q(tune_q), .mod_q(mod_q), .istep_q(istep_q),
  .frac_q(frac_q), .aux_q(aux_q), .phase_q(phase_q)
);

// File: tb/sim_pm_phase_accum.sv
module sim_pm_phase_accum;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] phase_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // bench model of the requirements
  logic [31:0] m_phase = '0, m_tune = '0, m_mod = '0, m_istep = '0, m_frac = '0, m_aux = '0;
  logic        m_mode = 1'b0;

  pm_phase_accum u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .phase_o(phase_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == MAX_CYCLES) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act cycles=%0d exp below %0d", cyc, MAX_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic model_carry();
    logic [32:0] s;
    s = {1'b0, m_aux} + {1'b0, m_frac};
    return m_mode && (m_mod != 0) && (s >= {1'b0, m_mod});
  endfunction

  function automatic logic [31:0] model_aux_next(input logic c);
    logic [32:0] s;
    s = {1'b0, m_aux} + {1'b0, m_frac};
    if (!m_mode) return 32'd0;
    if (c) s = s - {1'b0, m_mod};
    return s[31:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called at a negedge: check, drive, advance model, wait one clock
  task automatic cycle(input string tag, input logic we, input logic [2:0] a, input logic [31:0] d);
    logic c;
    check(tag, phase_o, m_phase);
    wr_en = we; wr_addr = a; wr_data = d;
    c = model_carry();
    m_phase = m_phase + (m_mode ? m_istep : m_tune) + {31'd0, c};
    m_aux = model_aux_next(c);
    if (we) begin
      case (a)
        3'd0: m_tune = d;
        3'd1: begin m_mod = d;   m_aux = 0; end
        3'd2: begin m_istep = d; m_aux = 0; end
        3'd3: begin m_frac = d;  m_aux = 0; end
        3'd4: begin m_mode = d[0]; m_aux = 0; end
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cycle(tag, 1'b0, 3'd0, 32'd0);
  endtask

  initial begin
    logic [31:0] p0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 reset", phase_o, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", phase_o, 32'd0);
    idle("R1 idle", 3);

    // R2 plain tone, including wrap of 2^32
    cycle("R2", 1'b1, 3'd0, 32'hC000_0001);
    idle("R2", 6);
    // R9: tuning change applies one edge later
    cycle("R9", 1'b1, 3'd0, 32'd5);
    idle("R9", 3);

    // R7 unmapped addresses change nothing
    cycle("R7", 1'b1, 3'd5, 32'hFFFF_FFFF);
    cycle("R7", 1'b1, 3'd7, 32'h1234_5678);
    idle("R7", 3);

    // R4 fraction 3/7 over a period of 7
    cycle("R4", 1'b1, 3'd1, 32'd7);
    cycle("R4", 1'b1, 3'd2, 32'd100);
    cycle("R4", 1'b1, 3'd3, 32'd3);
    cycle("R3", 1'b1, 3'd4, 32'd1);
    p0 = phase_o;
    idle("R4", 7);
    check("R4 period", phase_o - p0, 32'd703);
    idle("R3", 10);
    // R3 tuning word has no effect in the fractional mode
    cycle("R3", 1'b1, 3'd0, 32'h0BAD_0000);
    idle("R3", 5);

    // R6 clear on parameter write, not on tuning write
    idle("R6", 2);
    cycle("R6", 1'b1, 3'd0, 32'd9);
    idle("R6", 3);
    cycle("R6", 1'b1, 3'd2, 32'd50);
    idle("R6", 5);

    // R5 mode off then on restarts fraction
    cycle("R5", 1'b1, 3'd4, 32'd0);
    idle("R5", 4);
    cycle("R5", 1'b1, 3'd4, 32'd1);
    p0 = phase_o;
    idle("R5", 7);
    check("R5 restart", phase_o - p0, 32'd353);

    // R8 zero modulus
    cycle("R8", 1'b1, 3'd1, 32'd0);
    cycle("R8", 1'b1, 3'd3, 32'd9);
    p0 = phase_o;
    idle("R8", 6);
    check("R8 step", phase_o - p0, 32'd300);

    // large modulus near full scale
    cycle("R4", 1'b1, 3'd1, 32'hFFFF_FFFF);
    cycle("R4", 1'b1, 3'd3, 32'hFFFF_FFFE);
    idle("R4", 20);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]  a;
      logic [31:0] d;
      a = 3'($urandom % 8);
      d = $urandom;
      if (a == 3'd3) d = (m_mod != 0) ? ($urandom % m_mod) : d;
      if (a == 3'd1 && ($urandom % 2) == 0) d = 32'd1 + ($urandom % 1000);
      cycle("R3 R6 R9 random", ($urandom % 4) == 0, a, d);
    end
    idle("R9", 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule